// File: doc/BRIEF.md
# I2C SCL Divider Generator

This block produces the serial clock timing for an I2C master's byte engine. A 12-bit divider, held as a 7-bit low part and a 5-bit high part in two byte-wide registers, sets the SCL period. A separate mode bit selects standard or fast timing. Each mode has its own period formula, with a fixed overhead on top of the divider. The block drives an open-drain pull-down enable for SCL. It also gives the byte engine a strobe at the start of each low phase and a strobe when SCL is first seen high.

A third byte register holds a 3-bit input-clock frequency-range code. The code is passed through to the engine for its setup and hold spacing. Divider values below two are illegal, and with such a value no SCL edge is produced. The high phase is timed against the sampled SCL line, so a slave that holds SCL low lengthens the period.

The control state machine has four states. IDLE leaves SCL released. LOW pulls SCL down. HIGH counts released cycles. HOLD waits while SCL is released but still read low. Its transitions are:

- start: IDLE to LOW, when `run` is high, the divider is legal and SCL reads high.
- release: LOW to HIGH, when the low count is used up.
- stretch: HIGH to HOLD, when SCL reads low.
- resume: HOLD to HIGH, when SCL reads high.
- next period: HIGH or HOLD to LOW, on the last high cycle while `run` is high and the divider is legal.
- finish: HIGH or HOLD to IDLE, on the last high cycle otherwise.

Top module: `scl_div_gen`

## Requirements
- R1: After reset, SCL is released (`scl_drive_low`=0) and both strobes are low. `freq_range` reads 2, because the range register resets to byte 0x40. The divider is 0, so `div_bad` is 1.
- R2: Writes are selected by `wr_sel`. Code 0 is the clock control byte: bit 7 is the fast-mode bit and bits 6:0 are divider bits 6:0. Code 1 is the extended byte: bits 4:0 are divider bits 11:7. Code 2 is the range byte.
- R3: In standard mode the period is 2*(CC-1)+7 cycles. The low phase takes the larger half (CC+3 cycles) and the high phase takes CC+2 cycles.
- R4: In fast mode the period is 3*(CC-1)+9 cycles. The low phase takes two thirds of it (2*CC+4 cycles) and the high phase takes one third (CC+2 cycles).
- R5: While CC is below 2, `div_bad` is 1 and no period starts. If CC becomes illegal during a period, that period completes and SCL then stays released.
- R6: The high-phase count advances only on cycles where `scl_in` is high. Each cycle that a slave holds SCL low adds one cycle to the high phase.
- R7: `fall_stb` is high for exactly the first cycle of each low phase. `rise_stb` is high once per high phase, in the first cycle where `scl_in` reads high. The two strobes are never high together.
- R8: The mode and divider are captured at the start of each period. A write made during a period takes effect from the next period.
- R9: When `run` is dropped during a period, that period completes and SCL then stays released.
- R10: `freq_range` shows bits 7:5 of the last byte written to the range register. The other bits of that byte have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 clock control, 1 extended divider, 2 range |
| wr_data | input | 8 | Write data byte |
| run | input | 1 | Engine request for SCL periods |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle SCL is seen high in a high phase |
| freq_range | output | 3 | Input-clock frequency-range code |
| div_bad | output | 1 | Divider value below 2 |

## Verification
The assertions check these rules on every cycle:
- a low phase never starts while the divider is flagged illegal;
- SCL is never re-driven while a slave holds it low;
- the two strobes never overlap, and each appears only with the matching SCL level;
- every low phase lasts at least the minimum five cycles.

Other behaviour can only be shown by the bench's scenarios:
- the exact phase lengths of each mode across the divider range, including the split over both registers;
- the cycle in which a write takes effect;
- how much a stretch lengthens the high phase;
- the final period after the divider turns illegal or `run` is dropped.

// File: rtl/scl_div_pkg.sv
`timescale 1ns/1ps
package scl_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_HOLD = 2'd3
    } scl_state_t;

    localparam logic [1:0] SEL_CLK   = 2'd0;
    localparam logic [1:0] SEL_EXT   = 2'd1;
    localparam logic [1:0] SEL_RANGE = 2'd2;
endpackage

// File: rtl/scl_div_regs.sv
`timescale 1ns/1ps
module scl_div_regs
    import scl_div_pkg::*;
#(
    parameter int CC_W      = 12,
    parameter int CC_LO_W   = 7,
    parameter int DATA_W    = 8,
    parameter int RANGE_W   = 3,
    parameter logic [RANGE_W-1:0] RANGE_RST = 3'd2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               fast_mode,
    output logic [CC_W-1:0]    cc,
    output logic [RANGE_W-1:0] freq_range
);
    localparam int CC_HI_W = CC_W - CC_LO_W;

    logic               fast_q;
    logic [CC_LO_W-1:0] cc_lo_q;
    logic [CC_HI_W-1:0] cc_hi_q;
    logic [RANGE_W-1:0] rng_q;

    // Mode bit sits in the top bit of the control byte; range code in the top field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q  <= 1'b0;
            cc_lo_q <= '0;
            cc_hi_q <= '0;
            rng_q   <= RANGE_RST;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CLK: begin
                    fast_q  <= wr_data[DATA_W-1];
                    cc_lo_q <= wr_data[CC_LO_W-1:0];
                end
                SEL_EXT:   cc_hi_q <= wr_data[CC_HI_W-1:0];
                SEL_RANGE: rng_q   <= wr_data[DATA_W-1 -: RANGE_W];
                default: ;
            endcase
        end
    end

    assign fast_mode  = fast_q;
    assign cc         = {cc_hi_q, cc_lo_q};
    assign freq_range = rng_q;
endmodule

// File: rtl/scl_phase_calc.sv
`timescale 1ns/1ps
module scl_phase_calc #(
    parameter int CC_W  = 12,
    parameter int CNT_W = CC_W + 2
) (
    input  logic             fast_mode,
    input  logic [CC_W-1:0]  cc,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] high_len,
    output logic             cfg_bad
);
    localparam logic [CC_W-1:0] CC_MIN = CC_W'(2);

    logic [CNT_W-1:0] cc_w;

    // Standard: period 2CC+5, low CC+3 takes the odd cycle, high CC+2.
    // Fast: period 3CC+6, low 2CC+4 (two thirds), high CC+2 (one third).
    always_comb begin
        cc_w     = CNT_W'(cc);
        high_len = cc_w + CNT_W'(2);
        if (fast_mode) low_len = (cc_w << 1) + CNT_W'(4);
        else           low_len = cc_w + CNT_W'(3);
        cfg_bad  = (cc < CC_MIN);
    end
endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
module scl_phase_fsm
    import scl_div_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             scl_in,
    input  logic             cfg_bad,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    output logic             drive_low,
    output logic             fall_stb,
    output logic             rise_stb
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    scl_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] hi_q, hi_d;
    logic             fresh_q, fresh_d;
    logic             go;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hi_d    = hi_q;
        fresh_d = fresh_q;
        go      = run & ~cfg_bad;
        unique case (state_q)
            ST_IDLE: begin
                if (go && scl_in) begin
                    state_d = ST_LOW;
                    cnt_d   = low_len;
                    hi_d    = high_len;
                    fresh_d = 1'b1;
                end
            end
            ST_LOW: begin
                fresh_d = 1'b0;
                if (cnt_q == ONE) begin
                    state_d = ST_HIGH;
                    cnt_d   = hi_q;
                    fresh_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            ST_HIGH, ST_HOLD: begin
                if (!scl_in) begin
                    state_d = ST_HOLD;
                end else begin
                    fresh_d = 1'b0;
                    state_d = ST_HIGH;
                    if (cnt_q == ONE) begin
                        if (go) begin
                            state_d = ST_LOW;
                            cnt_d   = low_len;
                            hi_d    = high_len;
                            fresh_d = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hi_q    <= '0;
            fresh_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hi_q    <= hi_d;
            fresh_q <= fresh_d;
        end
    end

    always_comb begin
        drive_low = (state_q == ST_LOW);
        fall_stb  = (state_q == ST_LOW) && fresh_q;
        rise_stb  = ((state_q == ST_HIGH) || (state_q == ST_HOLD)) && fresh_q && scl_in;
    end
endmodule

// File: rtl/scl_div_gen.sv
`timescale 1ns/1ps
module scl_div_gen #(
    parameter int CC_W    = 12,
    parameter int CC_LO_W = 7,
    parameter int DATA_W  = 8,
    parameter int RANGE_W = 3,
    parameter logic [RANGE_W-1:0] RANGE_RST = 3'd2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               run,
    input  logic               scl_in,
    output logic               scl_drive_low,
    output logic               fall_stb,
    output logic               rise_stb,
    output logic [RANGE_W-1:0] freq_range,
    output logic               div_bad
);
    localparam int CNT_W = CC_W + 2;

    logic             fast_mode;
    logic [CC_W-1:0]  cc;
    logic [CNT_W-1:0] low_len, high_len;
    logic             cfg_bad;

    scl_div_regs #(
        .CC_W(CC_W), .CC_LO_W(CC_LO_W), .DATA_W(DATA_W),
        .RANGE_W(RANGE_W), .RANGE_RST(RANGE_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .fast_mode(fast_mode), .cc(cc),
        .freq_range(freq_range)
    );

    scl_phase_calc #(.CC_W(CC_W), .CNT_W(CNT_W)) u_calc (
        .fast_mode(fast_mode), .cc(cc), .low_len(low_len),
        .high_len(high_len), .cfg_bad(cfg_bad)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .scl_in(scl_in),
        .cfg_bad(cfg_bad), .low_len(low_len), .high_len(high_len),
        .drive_low(scl_drive_low), .fall_stb(fall_stb), .rise_stb(rise_stb)
    );

    assign div_bad = cfg_bad;
endmodule

// File: rtl/scl_div_gen_chk.sv
`timescale 1ns/1ps
module scl_div_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic scl_drive_low,
    input logic fall_stb,
    input logic rise_stb,
    input logic div_bad
);
    a_r5_no_illegal_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> !$past(div_bad));

    a_r6_hold_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drive_low && !scl_in) |=> !scl_drive_low);

    a_r7_fall_at_low_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> fall_stb);

    a_r7_fall_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> scl_drive_low);

    a_r7_rise_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (!scl_drive_low && scl_in));

    a_r7_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_stb, rise_stb}));

    a_r3_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |-> $past(scl_drive_low, 5));
endmodule

bind scl_div_gen scl_div_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .fall_stb(fall_stb), .rise_stb(rise_stb), .div_bad(div_bad)
);

// File: tb/scl_div_gen_test.sv
`timescale 1ns/1ps
module scl_div_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       run = 1'b0;
    logic       slave_hold = 1'b0;
    logic       scl_in;
    logic       scl_drive_low, fall_stb, rise_stb, div_bad;
    logic [2:0] freq_range;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Open-drain line model: low if either side pulls it
    assign scl_in = !(scl_drive_low || slave_hold);

    always #10 clk = ~clk;   // 50 MHz

    scl_div_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .run(run), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .fall_stb(fall_stb),
        .rise_stb(rise_stb), .freq_range(freq_range), .div_bad(div_bad)
    );

    // {fast, cc[11:0]}
    localparam logic [12:0] VEC [0:7] = '{
        {1'b0, 12'd2},   {1'b0, 12'd3},  {1'b0, 12'd100}, {1'b1, 12'd2},
        {1'b1, 12'd7},   {1'b0, 12'd130}, {1'b1, 12'd1000}, {1'b1, 12'd4095}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic set_div(input logic fast, input logic [11:0] cc);
        wr(2'd0, {fast, cc[6:0]});
        wr(2'd1, {3'b000, cc[11:7]});
    endtask

    // Expected phase lengths from the period formulas
    task automatic exp_len(input logic fast, input int cc, output int lo, output int hi);
        int p;
        if (!fast) begin
            p  = 2 * (cc - 1) + 7;
            lo = (p + 1) / 2;
            hi = p / 2;
        end else begin
            p  = 3 * (cc - 1) + 9;
            hi = p / 3;
            lo = p - hi;
        end
    endtask

    // Measure one period from its falling strobe to the next one.
    task automatic measure(input int stretch, input int mid_cc,
                           output int lo, output int hi, output int rises, output int rise_k);
        int g = 0;
        step();
        while (!fall_stb && g < 30000) begin step(); g++; end
        if (stretch > 0) slave_hold = 1'b1;
        if (mid_cc >= 0) begin
            wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'(mid_cc);
        end
        lo = 1; hi = 0; rises = 0; rise_k = 0;
        step();
        wr_en = 1'b0;
        while (scl_drive_low && lo < 30000) begin lo++; step(); end
        while (!fall_stb && hi < 30000) begin
            hi++;
            if (stretch > 0 && hi == stretch + 1) begin slave_hold = 1'b0; #1; end
            if (rise_stb) begin rises++; if (rise_k == 0) rise_k = hi; end
            step();
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired before completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lo, hi, rs, rk, falls, lows;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 drive", int'(scl_drive_low), 0);
        check("R1 fall_stb", int'(fall_stb), 0);
        check("R1 rise_stb", int'(rise_stb), 0);
        check("R1 freq_range", int'(freq_range), 2);
        check("R1 div_bad", int'(div_bad), 1);

        // R5 illegal divider never starts
        run = 1'b1;
        lows = 0;
        for (int i = 0; i < 40; i++) begin step(); if (scl_drive_low) lows++; end
        check("R5 no SCL with CC=0", lows, 0);
        set_div(1'b1, 12'd1);
        check("R5 div_bad CC=1", int'(div_bad), 1);
        lows = 0;
        for (int i = 0; i < 40; i++) begin step(); if (scl_drive_low) lows++; end
        check("R5 no SCL with CC=1", lows, 0);
        run = 1'b0;

        // R10 range code
        wr(2'd2, 8'hE0);
        check("R10 range 0xE0", int'(freq_range), 7);
        wr(2'd2, 8'h1F);
        check("R10 low bits ignored", int'(freq_range), 0);
        wr(2'd2, 8'h60);
        check("R10 range 0x60", int'(freq_range), 3);

        // R2 R3 R4 vector walk
        run = 1'b1;
        for (int v = 0; v < 8; v++) begin
            int elo, ehi;
            set_div(VEC[v][12], VEC[v][11:0]);
            check("R2 div legal", int'(div_bad), 0);
            measure(0, -1, lo, hi, rs, rk);
            measure(0, -1, lo, hi, rs, rk);
            exp_len(VEC[v][12], int'(VEC[v][11:0]), elo, ehi);
            check(VEC[v][12] ? "R4 fast low" : "R3 std low", lo, elo);
            check(VEC[v][12] ? "R4 fast high" : "R3 std high", hi, ehi);
            check("R7 one rise per high phase", rs, 1);
        end

        // R8 write during a period applies next period
        set_div(1'b0, 12'd2);
        measure(0, -1, lo, hi, rs, rk);
        measure(0, 10, lo, hi, rs, rk);
        check("R8 current period low", lo, 5);
        check("R8 current period high", hi, 4);
        measure(0, -1, lo, hi, rs, rk);
        check("R8 next period low", lo, 13);
        check("R8 next period high", hi, 12);

        // R6 stretching
        set_div(1'b0, 12'd2);
        measure(0, -1, lo, hi, rs, rk);
        measure(6, -1, lo, hi, rs, rk);
        check("R6 low unaffected", lo, 5);
        check("R6 high stretched", hi, 10);
        check("R7 rise after release", rk, 7);
        check("R7 single rise", rs, 1);

        // R5 divider turns illegal mid-run
        measure(0, -1, lo, hi, rs, rk);
        wr(2'd0, 8'h01);
        falls = 0; rs = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (fall_stb) falls++;
            if (rise_stb) rs++;
        end
        check("R5 no new period", falls, 0);
        check("R5 period completed", rs, 1);
        check("R5 released", int'(scl_drive_low), 0);

        // R9 run dropped mid-period
        set_div(1'b0, 12'd2);
        step();
        while (!fall_stb) step();
        run = 1'b0;
        falls = 0; rs = 0; lows = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (fall_stb) falls++;
            if (rise_stb) rs++;
            if (scl_drive_low) lows++;
        end
        check("R9 low completes", lows, 4);
        check("R9 high completes", rs, 1);
        check("R9 no new period", falls, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule